// File: doc/BRIEF.md
# Dual-Port Synthesizer Configuration Interface

This block keeps the configuration words of a frequency synthesizer: a 9-bit loop-divider value, a 2-bit output-ratio code and a 3-bit test-select code. Two ports can write these words. The parallel port has a strobe and pins for the divider and ratio values. The serial port has three wires: data, clock and load. Shifted bits collect in a 14-bit shift register. A separate load strobe moves that register into the configuration.

All strobes, the serial clock and the data pins arrive without any timing relation to the system clock. Each passes through a two-flop synchronizer, and edges are detected on the synchronized copies. A small state machine picks the source of the configuration registers in each cycle. The state names and their transitions are:

- `ST_PAR`: entered from any state whenever the parallel strobe is low. The pins feed the configuration and the test code is zero.
- `ST_SER`: entered from `ST_HOLD` or `ST_PAR` when the parallel strobe is high and the serial load strobe is high. The shift register feeds all three fields.
- `ST_HOLD`: entered from `ST_PAR` when the parallel strobe rises with the serial load low, and from `ST_SER` when the serial load falls. The values are frozen.

The state after reset is `ST_HOLD`, with every field at zero. A typical system holds the parallel strobe low through power-up and then releases it, which captures the pin values. Later it refines the settings over the serial port.

Top module: `synth_cfg_port`

## Requirements
- R1: After reset, the divider, ratio and test outputs are zero and the shift output is 0. They stay zero until a parallel or serial load occurs.
- R2: Each rising edge of the serial clock shifts the serial data bit into the 14-bit shift register. The shift output shows the bit that left the far end on that edge, which is the bit sent 14 edges earlier.
- R3: In the serial stream, the first three bits form the test code, the next two form the ratio code, and the last nine form the divider value. Each field is sent MSB first.
- R4: While the parallel strobe is high and the serial load strobe is high, the outputs follow the shift register. When the serial load strobe falls, the values held at that moment are kept.
- R5: While the parallel strobe is low, the divider and ratio outputs follow the parallel pins. On the rising edge of the strobe they capture the pins, and later pin changes have no effect.
- R6: While the parallel strobe is low, the test code is 000. The parallel port cannot set it, so it stays 000 after the strobe rises until a serial load.
- R7: While the parallel strobe is low, the serial load strobe has no effect, even when both strobes change in the same cycle.
- R8: Shifting with the serial load strobe low leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_ld | input | 1 | Parallel strobe: transparent when low, captures on rise |
| par_m | input | 9 | Parallel divider value |
| par_n | input | 2 | Parallel ratio code |
| ser_clk | input | 1 | Serial clock, shifts on rise |
| ser_dat | input | 1 | Serial data |
| ser_ld | input | 1 | Serial load: transparent when high, holds on fall |
| cfg_m | output | 9 | Active divider value |
| cfg_n | output | 2 | Active ratio code |
| cfg_t | output | 3 | Active test-select code |
| shift_out | output | 1 | Last bit shifted out of the register |

## Verification
Two events can fall in the same cycle: the parallel strobe going low and a serial load going high. The bench raises the serial load strobe in the same cycle that it drops the parallel strobe. It then expects the outputs to match the pins and the test code to be zero, not the shift-register contents. A second overlap is a serial clock edge while the serial load strobe is high. That case is judged by checking that the outputs follow the register one shift later and freeze once the strobe falls.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_PAR  = 2'd1,
        ST_SER  = 2'd2
    } cfg_state_e;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d_in;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign d_out = pipe[STAGES-1];

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
    parameter int LEN = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_s,
    input  logic           sdat_s,
    output logic [LEN-1:0] sr,
    output logic           bit_out
);

    logic sclk_d;
    logic rise;

    assign rise = sclk_s & ~sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            sr      <= '0;
            bit_out <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (rise) begin
                sr      <= {sr[LEN-2:0], sdat_s};
                bit_out <= sr[LEN-1];
            end
        end
    end

    // R2: register moves only on a synchronized serial clock rise
    a_r2_no_shift_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_s && !sclk_d) |=> $stable(sr));

    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !sclk_d) |=> (sr[0] == $past(sdat_s)) && (bit_out == $past(sr[LEN-1])));

endmodule

// File: rtl/cfg_latch_fsm.sv
module cfg_latch_fsm
    import synth_cfg_pkg::*;
#(
    parameter int M_BITS = 9,
    parameter int N_BITS = 2,
    parameter int T_BITS = 3,
    localparam int SR_LEN = M_BITS + N_BITS + T_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_s,
    input  logic              sld_s,
    input  logic [M_BITS-1:0] pm_s,
    input  logic [N_BITS-1:0] pn_s,
    input  logic [SR_LEN-1:0] sr,
    output logic [M_BITS-1:0] cfg_m,
    output logic [N_BITS-1:0] cfg_n,
    output logic [T_BITS-1:0] cfg_t
);

    cfg_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD: begin
                if (!par_s)     state_nx = ST_PAR;
                else if (sld_s) state_nx = ST_SER;
            end
            ST_PAR: begin
                if (par_s) state_nx = sld_s ? ST_SER : ST_HOLD;
            end
            ST_SER: begin
                if (!par_s)      state_nx = ST_PAR;
                else if (!sld_s) state_nx = ST_HOLD;
            end
            default: state_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_m <= '0;
            cfg_n <= '0;
            cfg_t <= '0;
        end else begin
            unique case (state_nx)
                ST_PAR: begin
                    cfg_m <= pm_s;
                    cfg_n <= pn_s;
                    cfg_t <= '0;
                end
                ST_SER: begin
                    cfg_t <= sr[SR_LEN-1 -: T_BITS];
                    cfg_n <= sr[M_BITS +: N_BITS];
                    cfg_m <= sr[M_BITS-1:0];
                end
                default: ;
            endcase
        end
    end

    // R6: test code zero while parallel strobe low
    a_r6_t_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !par_s |=> (cfg_t == '0));

    // R5: pins pass through while parallel strobe low
    a_r5_par_track: assert property (@(posedge clk) disable iff (!rst_n)
        !par_s |=> (cfg_m == $past(pm_s)) && (cfg_n == $past(pn_s)));

    // R4 / R3: serial fields taken from shift register
    a_r4_ser_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (par_s && sld_s) |=> (cfg_m == $past(sr[M_BITS-1:0])));

    a_r3_t_field: assert property (@(posedge clk) disable iff (!rst_n)
        (par_s && sld_s) |=> (cfg_t == $past(sr[SR_LEN-1 -: T_BITS])));

    // R8: nothing moves without a load
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (par_s && !sld_s) |=> $stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t));

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port #(
    parameter int M_BITS = 9,
    parameter int N_BITS = 2,
    parameter int T_BITS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_ld,
    input  logic [M_BITS-1:0] par_m,
    input  logic [N_BITS-1:0] par_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_ld,
    output logic [M_BITS-1:0] cfg_m,
    output logic [N_BITS-1:0] cfg_n,
    output logic [T_BITS-1:0] cfg_t,
    output logic              shift_out
);

    localparam int SR_LEN  = M_BITS + N_BITS + T_BITS;
    localparam int PIN_W   = M_BITS + N_BITS;

    logic [3:0]        ctl_s;
    logic [PIN_W-1:0]  pins_s;
    logic [SR_LEN-1:0] sr;

    // order: {parallel strobe, serial clock, serial load, serial data}
    cfg_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({par_ld, ser_clk, ser_ld, ser_dat}),
        .d_out (ctl_s)
    );

    cfg_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({par_n, par_m}),
        .d_out (pins_s)
    );

    cfg_shifter #(.LEN(SR_LEN)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (ctl_s[2]),
        .sdat_s  (ctl_s[0]),
        .sr      (sr),
        .bit_out (shift_out)
    );

    cfg_latch_fsm #(.M_BITS(M_BITS), .N_BITS(N_BITS), .T_BITS(T_BITS)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .par_s (ctl_s[3]),
        .sld_s (ctl_s[1]),
        .pm_s  (pins_s[M_BITS-1:0]),
        .pn_s  (pins_s[PIN_W-1 -: N_BITS]),
        .sr    (sr),
        .cfg_m (cfg_m),
        .cfg_n (cfg_n),
        .cfg_t (cfg_t)
    );

    // R1: outputs stay cleared until the first load after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (cfg_m == '0) && (cfg_t == '0) && (shift_out == 1'b0));

endmodule

// File: tb/test_synth_cfg_port.sv
module test_synth_cfg_port;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       par_ld = 1;
    logic [8:0] par_m = 0;
    logic [1:0] par_n = 0;
    logic       ser_clk = 0;
    logic       ser_dat = 0;
    logic       ser_ld = 0;
    logic [8:0] cfg_m;
    logic [1:0] cfg_n;
    logic [2:0] cfg_t;
    logic       shift_out;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [13:0] exp_sr = '0;
    logic        exp_out = 0;

    always #2.5 clk = ~clk;

    synth_cfg_port i_synth_cfg_port (
        .clk(clk), .rst_n(rst_n), .par_ld(par_ld), .par_m(par_m), .par_n(par_n),
        .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .shift_out(shift_out)
    );

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_dat = b;
        wait_cyc(3);
        ser_clk = 1;
        exp_out = exp_sr[13];
        exp_sr  = {exp_sr[12:0], b};
        wait_cyc(4);
        ser_clk = 0;
        wait_cyc(3);
    endtask

    task automatic send_word(input logic [13:0] w);
        for (int i = 13; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_sld();
        ser_ld = 1;
        wait_cyc(6);
        ser_ld = 0;
        wait_cyc(6);
    endtask

    task automatic t_reset();
        wait_cyc(8);
        chk("R1 cfg_m", cfg_m, 0);
        chk("R1 cfg_n", cfg_n, 0);
        chk("R1 cfg_t", cfg_t, 0);
        chk("R1 shift_out", shift_out, 0);
    endtask

    task automatic t_parallel();
        par_m = 9'd262; par_n = 2'b01; par_ld = 0;
        wait_cyc(8);
        chk("R5 track m", cfg_m, 262);
        chk("R5 track n", cfg_n, 1);
        par_m = 9'd300; par_n = 2'b10;
        wait_cyc(8);
        chk("R5 follow m", cfg_m, 300);
        par_ld = 1;
        wait_cyc(8);
        par_m = 9'd5; par_n = 2'b11;
        wait_cyc(8);
        chk("R5 captured m", cfg_m, 300);
        chk("R5 captured n", cfg_n, 2);
        chk("R6 t zero", cfg_t, 0);
    endtask

    task automatic t_serial();
        // T=101, N=11, M=0x1A5 (LSB 1)
        send_word({3'b101, 2'b11, 9'h1A5});
        chk("R8 no load yet", cfg_m, 300);
        pulse_sld();
        chk("R3 t field", cfg_t, 5);
        chk("R3 n field", cfg_n, 3);
        chk("R3 m field", cfg_m, 9'h1A5);
    endtask

    task automatic t_shift_hold();
        send_word({3'b010, 2'b00, 9'h0F0});
        chk("R2 out after 14", shift_out, 1);
        chk("R8 hold m", cfg_m, 9'h1A5);
        chk("R8 hold t", cfg_t, 5);
        send_bit(1'b1);
        chk("R2 out next", shift_out, int'(exp_out));
        chk("R2 out is word msb", shift_out, 0);
    endtask

    task automatic t_transparent();
        ser_ld = 1;
        wait_cyc(6);
        chk("R4 open m", cfg_m, int'(exp_sr[8:0]));
        chk("R4 open t", cfg_t, int'(exp_sr[13:11]));
        send_bit(1'b0);
        wait_cyc(4);
        chk("R4 follow m", cfg_m, int'(exp_sr[8:0]));
        chk("R4 follow n", cfg_n, int'(exp_sr[10:9]));
        ser_ld = 0;
        wait_cyc(6);
        begin
            logic [13:0] held = exp_sr;
            send_bit(1'b1);
            wait_cyc(4);
            chk("R4 frozen m", cfg_m, int'(held[8:0]));
            chk("R4 frozen t", cfg_t, int'(held[13:11]));
        end
    endtask

    task automatic t_force_t();
        par_m = 9'd400; par_n = 2'b00; par_ld = 0;
        wait_cyc(8);
        chk("R6 forced t", cfg_t, 0);
        chk("R5 m follows pins", cfg_m, 400);
        par_ld = 1;
        wait_cyc(8);
        chk("R6 t stays zero", cfg_t, 0);
    endtask

    task automatic t_priority();
        send_word({3'b111, 2'b01, 9'h033});
        par_m = 9'd200; par_n = 2'b10;
        @(negedge clk);
        par_ld = 0;
        ser_ld = 1;
        wait_cyc(8);
        chk("R7 same cycle m", cfg_m, 200);
        chk("R7 same cycle n", cfg_n, 2);
        chk("R7 same cycle t", cfg_t, 0);
        ser_ld = 0;
        wait_cyc(6);
        pulse_sld();
        chk("R7 pulse ignored m", cfg_m, 200);
        chk("R7 pulse ignored t", cfg_t, 0);
        par_ld = 1;
        wait_cyc(8);
        chk("R7 capture after", cfg_m, 200);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1;
        t_reset();
        t_parallel();
        t_serial();
        t_shift_hold();
        t_transparent();
        t_force_t();
        t_priority();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule